// File: doc/BRIEF.md
# One-Shot Serial Configuration Register for a Clock Fan-Out

This block configures a ten-output clock fan-out. A configuration clock, a mode input and a serial data pin drive it. It produces ten per-channel enable lines and one line that picks the clock source. The analog buffers, the clock multiplexer itself and the output signalling are outside this block.

In programmed mode (`mode_prog` high), each rising edge of `clk` moves one bit from `ser_in` into an eleven-stage shift chain. After eleven such edges, the next edge copies the word into a control register. That copy happens once, and from then on the register and the chain ignore the serial pin. A rising edge with `mode_prog` low clears the chain, the bit counter, the lock flag and the control register, and that is the only way to start a new word.

In standard mode (`mode_prog` low), the control register has no effect on the outputs. All channels are on and `ser_in` picks the clock source directly. The asynchronous `rst_n` gives the same cleared state at power-up.

Top module: `clk_fanout_cfg`

## Requirements
- R1: While `rst_n` is low, and in programmed mode before any commit, `chan_en` is 10'h3FF and `src_sel` is 0.
- R2: With `mode_prog` low, `chan_en` is 10'h3FF and `src_sel` equals `ser_in` in the same cycle, including changes between clock edges (0 selects source 0, 1 selects source 1).
- R3: With `mode_prog` high, each of the first eleven edges shifts `ser_in` into the chain. The bit taken on the first edge is word bit 0 and the bit on the eleventh edge is word bit 10.
- R4: The outputs keep the cleared value through the eleventh shift edge and take the new word on the twelfth consecutive programmed-mode edge.
- R5: Word bit k (k = 0..9) drives `chan_en[9-k]`, and word bit 10 drives `src_sel`. A 1 enables a channel, and `src_sel` = 1 selects source 1.
- R6: After a commit, further programmed-mode edges change neither `chan_en` nor `src_sel`, whatever `ser_in` does.
- R7: One edge with `mode_prog` low clears the counter, the lock and the control register. On return to programmed mode the outputs show the R1 value and a fresh word can be loaded.
- R8: If `mode_prog` goes low before the commit edge, including on the twelfth edge itself, the partial word is dropped and is never committed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Configuration clock; every register updates on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_prog | input | 1 | 1 = programmed mode, 0 = standard mode plus clocked clear |
| ser_in | input | 1 | Serial data in programmed mode; source select in standard mode |
| chan_en | output | 10 | Per-channel output enables, 1 = enabled |
| src_sel | output | 1 | Clock source select, 0 = source 0, 1 = source 1 |

## Verification
The commit and the clocked clear can land on the same edge: the twelfth edge after a full word can arrive with `mode_prog` already low. The bench provokes this by shifting eleven bits and then dropping `mode_prog` instead of giving the commit pulse. The scoreboard then expects the standard-mode outputs, and after `mode_prog` returns high it expects the cleared value rather than the shifted word. A second overlap comes from a clear that arrives while the register is locked. Release from the lock and the return to the bypass path are judged on the same edge.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  localparam int unsigned NUM_CH_DEF = 10;
  localparam int unsigned WORD_W_DEF = NUM_CH_DEF + 1;
  localparam int unsigned CNT_W_DEF  = $clog2(WORD_W_DEF + 1);
endpackage

// File: rtl/cfg_shifter.sv
module cfg_shifter #(
  parameter int unsigned W = cfg_pkg::WORD_W_DEF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] word
);
  logic [W-1:0] word_d, word_q;

  always_comb begin
    word_d = word_q;
    if (clr)           word_d = '0;
    else if (shift_en) word_d = {word_q[W-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_d;
  end

  assign word = word_q;
endmodule

// File: rtl/cfg_seq.sv
module cfg_seq #(
  parameter int unsigned W     = cfg_pkg::WORD_W_DEF,
  parameter int unsigned CNT_W = cfg_pkg::CNT_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             act,
  output logic             shift_en,
  output logic             commit_en,
  output logic             committed,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(W);

  logic [CNT_W-1:0] cnt_d, cnt_q;
  logic             lock_d, lock_q;

  assign shift_en  = act && (cnt_q != FULL);
  assign commit_en = act && (cnt_q == FULL) && !lock_q;

  always_comb begin
    cnt_d  = cnt_q;
    lock_d = lock_q;
    if (clr) begin
      cnt_d  = '0;
      lock_d = 1'b0;
    end else begin
      if (shift_en)  cnt_d  = cnt_q + 1'b1;
      if (commit_en) lock_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      lock_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      lock_q <= lock_d;
    end
  end

  assign committed = lock_q;
  assign cnt       = cnt_q;
endmodule

// File: rtl/cfg_ctrl_reg.sv
module cfg_ctrl_reg #(
  parameter int unsigned NUM_CH = cfg_pkg::NUM_CH_DEF,
  localparam int unsigned W     = NUM_CH + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              load,
  input  logic [W-1:0]      word,
  output logic [NUM_CH-1:0] ch_en,
  output logic              src
);
  // Chain stage 0 holds the last bit shifted (word bit 10, the source select).
  // Stage j+1 holds word bit 9-j, which drives channel j.
  logic [NUM_CH-1:0] map_ch;
  logic [NUM_CH-1:0] ch_d, ch_q;
  logic              src_d, src_q;

  for (genvar j = 0; j < NUM_CH; j++) begin : g_map
    assign map_ch[j] = word[j+1];
  end

  always_comb begin
    ch_d  = ch_q;
    src_d = src_q;
    if (clr) begin
      ch_d  = '1;
      src_d = 1'b0;
    end else if (load) begin
      ch_d  = map_ch;
      src_d = word[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch_q  <= '1;
      src_q <= 1'b0;
    end else begin
      ch_q  <= ch_d;
      src_q <= src_d;
    end
  end

  assign ch_en = ch_q;
  assign src   = src_q;
endmodule

// File: rtl/clk_fanout_cfg.sv
module clk_fanout_cfg #(
  parameter int unsigned NUM_CH = cfg_pkg::NUM_CH_DEF,
  localparam int unsigned W     = NUM_CH + 1,
  localparam int unsigned CNT_W = $clog2(W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_prog,
  input  logic              ser_in,
  output logic [NUM_CH-1:0] chan_en,
  output logic              src_sel
);
  logic             clr;
  logic             shift_en, commit_en, committed;
  logic [CNT_W-1:0] cnt;
  logic [W-1:0]     word;
  logic [NUM_CH-1:0] reg_ch;
  logic             reg_src;

  assign clr = !mode_prog;

  cfg_seq #(.W(W), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .clr(clr), .act(mode_prog),
    .shift_en(shift_en), .commit_en(commit_en),
    .committed(committed), .cnt(cnt)
  );

  cfg_shifter #(.W(W)) u_shift (
    .clk(clk), .rst_n(rst_n), .clr(clr), .shift_en(shift_en),
    .din(ser_in), .word(word)
  );

  cfg_ctrl_reg #(.NUM_CH(NUM_CH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .clr(clr), .load(commit_en),
    .word(word), .ch_en(reg_ch), .src(reg_src)
  );

  always_comb begin
    if (mode_prog) begin
      chan_en = reg_ch;
      src_sel = reg_src;
    end else begin
      chan_en = '1;
      src_sel = ser_in;
    end
  end
endmodule

// File: rtl/clk_fanout_cfg_chk.sv
module clk_fanout_cfg_chk #(
  parameter int unsigned NUM_CH = 10,
  parameter int unsigned CNT_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_prog,
  input logic [NUM_CH-1:0] chan_en,
  input logic              src_sel,
  input logic              committed,
  input logic [CNT_W-1:0]  cnt
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(NUM_CH + 1);
  logic past_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL);

  p_commit_after_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $rose(committed)) |-> ($past(cnt) == FULL && $past(mode_prog)));

  p_hold_until_commit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_prog && !committed) |-> (chan_en == {NUM_CH{1'b1}} && !src_sel));

  p_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(committed) && $past(mode_prog) && mode_prog)
      |-> ($stable(chan_en) && $stable(src_sel)));

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(!mode_prog)) |-> (cnt == '0 && !committed));
endmodule

bind clk_fanout_cfg clk_fanout_cfg_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_prog(mode_prog), .chan_en(chan_en),
  .src_sel(src_sel), .committed(committed), .cnt(cnt)
);

// File: tb/tb_clk_fanout_cfg.sv
module tb_clk_fanout_cfg;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [9:0] ch;
    logic       src;
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_prog = 1'b1;
  logic       ser_in = 1'b0;
  logic [9:0] chan_en;
  logic       src_sel;

  int n_tests = 0;
  int n_fail  = 0;
  bit ended   = 0;
  exp_t q[$];

  bit [10:0] m_word;
  int        m_cnt;
  bit        m_done;
  bit [9:0]  m_ch;
  bit        m_src;

  always #(CLK_PERIOD/2) clk = ~clk;

  clk_fanout_cfg dut (
    .clk(clk), .rst_n(rst_n), .mode_prog(mode_prog), .ser_in(ser_in),
    .chan_en(chan_en), .src_sel(src_sel)
  );

  task automatic check(input logic [9:0] ch, input logic src, input string tag);
    n_tests++;
    if (chan_en !== ch || src_sel !== src) begin
      n_fail++;
      $display("FAIL %s: got chan_en=%h src_sel=%b, expected chan_en=%h src_sel=%b",
               tag, chan_en, src_sel, ch, src);
    end
  endtask

  task automatic model_clear();
    m_word = '0; m_cnt = 0; m_done = 0; m_ch = '1; m_src = 0;
  endtask

  // Driver: apply inputs, take one edge, push the expected outputs.
  task automatic step(input bit en, input bit si, input string tag);
    exp_t e;
    mode_prog = en;
    ser_in    = si;
    @(posedge clk);
    if (!en) model_clear();
    else if (m_cnt < 11) begin
      m_word[m_cnt] = si;
      m_cnt++;
    end else if (!m_done) begin
      for (int k = 0; k < 10; k++) m_ch[9-k] = m_word[k];
      m_src  = m_word[10];
      m_done = 1;
    end
    e.ch  = en ? m_ch : 10'h3FF;
    e.src = en ? m_src : si;
    e.tag = tag;
    q.push_back(e);
    @(negedge clk);
  endtask

  task automatic shift_word(input bit [10:0] d, input string tag);
    for (int k = 0; k < 11; k++) step(1'b1, d[k], tag);
  endtask

  // Monitor: compare each result a quarter period after its edge.
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(e.ch, e.src, e.tag);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 3000);
    if (!ended) begin
      ended = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    model_clear();
    #(CLK_PERIOD*2 + 1);
    check(10'h3FF, 1'b0, "R1 in reset");
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b1, 1'b1, "R1 after reset");

    // R2: standard mode bypass, both source values and a change between edges
    step(1'b0, 1'b0, "R2 std src0");
    step(1'b0, 1'b1, "R2 std src1");
    ser_in = 1'b0; #1;
    check(10'h3FF, 1'b0, "R2 comb src0");
    ser_in = 1'b1; #1;
    check(10'h3FF, 1'b1, "R2 comb src1");
    step(1'b0, 1'b0, "R7 clear");

    // R3/R4/R5: word A; outputs hold through shifts, update on commit edge
    shift_word(11'b101_1000_1101, "R4 hold during shift");
    step(1'b1, 1'b0, "R5 commit word A");
    // R6: further pulses ignored
    for (int k = 0; k < 6; k++) step(1'b1, k[0], "R6 locked");

    // R7: clear then reload a different word (D10 = 0)
    step(1'b0, 1'b1, "R7 clear from locked");
    step(1'b1, 1'b0, "R7 cleared value");
    step(1'b0, 1'b0, "R7 clear");
    shift_word(11'b010_0111_0010, "R3 shift word B");
    step(1'b1, 1'b1, "R5 commit word B");
    step(1'b1, 1'b0, "R6 locked B");

    // R8: partial word dropped
    step(1'b0, 1'b0, "R7 clear");
    for (int k = 0; k < 5; k++) step(1'b1, 1'b0, "R8 partial");
    step(1'b0, 1'b1, "R8 abandon");
    shift_word(11'b111_1111_1111, "R3 shift all ones");
    step(1'b1, 1'b0, "R5 commit all ones");

    // R8: clear on the would-be commit edge
    step(1'b0, 1'b0, "R7 clear");
    shift_word(11'b100_0000_0000, "R4 hold");
    step(1'b0, 1'b0, "R8 clear on commit edge");
    step(1'b1, 1'b0, "R8 no commit after clear");

    // All-zero word: every channel off, source 0
    step(1'b0, 1'b0, "R7 clear");
    shift_word(11'b000_0000_0000, "R3 shift zeros");
    step(1'b1, 1'b1, "R5 commit zeros");
    step(1'b1, 1'b1, "R6 locked zeros");

    @(posedge clk);
    @(negedge clk);
    if (!ended) begin
      ended = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule